// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit of a processor that spends several clock cycles on each instruction. It covers five instruction kinds: register-to-register arithmetic, word load, word store, branch on equality and unconditional jump. The block steps through ten control states. In each state it drives the enables and multiplexer selects that the datapath needs for that cycle. These cover the program counter, the shared instruction/data memory, the register file with its two operand latches, and the ALU with its result register. The datapath itself lies outside the block. It feeds back the opcode and function fields of the instruction register, and this block turns them into the next state and the ALU operation code.

Each state is built from four per-group micro-operations, one each for the program counter, memory, register file and ALU. The micro-operations are then expanded into control lines. Every instruction starts with a fetch state and a common decode state. Load and store then share an address-calculation state before their paths part. All control lines come from registers and change only on the clock edge. The 3-bit ALU code is the one exception: it is decoded from the registered ALU mode and the live function field. A synchronous, active-high reset returns the sequencer to fetch.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the sequencer enters fetch. In fetch the outputs are: mem_rd=1, ir_load=1, pc_wr_always=1, pc_sel=1, alu_a_sel=0, alu_b_sel=1, alu_op=add (3'b010). Every other control line is 0.
- R2: Fetch is always followed by decode. In decode: a_load=1, b_load=1, res_load=1, alu_a_sel=0, alu_b_sel=3, alu_op=add. Every other control line is 0.
- R3: The opcode seen during decode selects the path. 0x00 selects register arithmetic, 0x23 load, 0x2B store, 0x04 branch and 0x02 jump. Any other opcode goes straight back to fetch. A full instruction therefore takes 4, 5, 4, 3, 3 or 2 cycles respectively.
- R4: Register arithmetic runs an execute state and then a write-back state. Execute drives alu_a_sel=1, alu_b_sel=0 and res_load=1, with alu_op taken from the function field. Write-back drives rf_wr=1, rf_dst_rd=1 and rf_from_mem=0. Fetch follows.
- R5: Load and store share an address state with alu_a_sel=1, alu_b_sel=2, alu_op=add and res_load=1. Store then goes to its write state and load to its read state.
- R6: The store write state drives mem_wr=1 and mem_addr_data=1, with mem_rd=0, ir_load=0 and dr_load=0. Fetch follows.
- R7: The load read state drives mem_rd=1, mem_addr_data=1 and dr_load=1. It is followed by a write-back with rf_wr=1, rf_dst_rd=0 and rf_from_mem=1, and then by fetch.
- R8: The branch state drives alu_a_sel=1, alu_b_sel=0, alu_op=subtract (3'b110), pc_wr_if_zero=1, pc_wr_always=0 and pc_sel=0. Fetch follows.
- R9: The jump state drives pc_wr_always=1 and pc_sel=2. Fetch follows.
- R10: In the function-driven mode, alu_op decodes the function field: 0x20 gives 3'b010 (add), 0x22 gives 3'b110 (subtract), 0x24 gives 3'b000 (AND), 0x25 gives 3'b001 (OR) and 0x2A gives 3'b111 (set-less-than). Any other function value gives add.
- R11: In every state, each control line that the state does not name is 0. alu_op shows add whenever the ALU group is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| pc_wr_always | output | 1 | Unconditional program counter write |
| pc_wr_if_zero | output | 1 | Program counter write qualified by the ALU zero flag |
| pc_sel | output | 2 | PC source: 0 result register, 1 ALU output, 2 jump target |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_addr_data | output | 1 | Memory address source: 0 program counter, 1 result register |
| ir_load | output | 1 | Instruction register load |
| dr_load | output | 1 | Data register load |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_rd | output | 1 | Write address: 1 rd field, 0 rt field |
| rf_from_mem | output | 1 | Write data: 1 data register, 0 result register |
| a_load | output | 1 | Operand A latch load |
| b_load | output | 1 | Operand B latch load |
| alu_a_sel | output | 1 | ALU first input: 0 program counter, 1 operand A |
| alu_b_sel | output | 2 | ALU second input: 0 B, 1 constant 4, 2 memory offset, 3 branch offset |
| alu_op | output | 3 | ALU operation code |
| res_load | output | 1 | Result register load |

## Verification
The assertions check the ordering rules on every cycle. After reset comes fetch, and fetch is followed by decode. Decode lasts a single cycle. The address state always leads to a memory write or a data-register load, and each final state hands over to fetch. Memory read and write, and the two program-counter write kinds, are never active together. Only the bench's scenarios can show that each opcode and function code yields the exact state path, instruction length and per-state control word. The same holds for unlisted opcodes and function values, and for a reset arriving in the middle of a load.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int ALU_OP_W = 3;
  localparam logic [ALU_OP_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_OP_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALU_OP_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_OP_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_OP_W-1:0] ALU_SLT = 3'b111;

  typedef enum logic [3:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_EXEC   = 4'd2,
    ST_RWB    = 4'd3,
    ST_MADDR  = 4'd4,
    ST_STORE  = 4'd5,
    ST_LREAD  = 4'd6,
    ST_LWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9
  } state_t;

  // per-group micro-operations
  typedef enum logic [1:0] {PCU_HOLD, PCU_STEP, PCU_COND, PCU_JUMP} pc_uop_t;
  typedef enum logic [1:0] {MEMU_IDLE, MEMU_FETCH, MEMU_READ, MEMU_WRITE} mem_uop_t;
  typedef enum logic [1:0] {RFU_IDLE, RFU_OPERANDS, RFU_RES2RD, RFU_DR2RT} rf_uop_t;
  typedef enum logic [2:0] {ALUU_IDLE, ALUU_STEP, ALUU_BRTGT, ALUU_ARITH,
                            ALUU_ADDR, ALUU_CMP} alu_uop_t;

  typedef enum logic [1:0] {MODE_ADD = 2'd0, MODE_SUB = 2'd1, MODE_FUNCT = 2'd2} alu_mode_t;

  typedef struct packed {
    logic       pc_wr_always;
    logic       pc_wr_if_zero;
    logic [1:0] pc_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       mem_addr_data;
    logic       ir_load;
    logic       dr_load;
    logic       rf_wr;
    logic       rf_dst_rd;
    logic       rf_from_mem;
    logic       a_load;
    logic       b_load;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    alu_mode_t  alu_mode;
    logic       res_load;
  } ctrl_t;

endpackage

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
#(
  parameter int              OP_W      = 6,
  parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
  input  state_t          cur,
  input  logic [OP_W-1:0] opcode,
  output state_t          nxt
);

  state_t dispatch;

  // path selection out of the common decode state
  always_comb begin
    if (opcode == OP_RTYPE)                             dispatch = ST_EXEC;
    else if (opcode == OP_LOAD || opcode == OP_STORE)   dispatch = ST_MADDR;
    else if (opcode == OP_BRANCH)                       dispatch = ST_BRANCH;
    else if (opcode == OP_JUMP)                         dispatch = ST_JUMP;
    else                                                dispatch = ST_FETCH;
  end

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = dispatch;
      ST_EXEC:   nxt = ST_RWB;
      ST_MADDR:  nxt = (opcode == OP_STORE) ? ST_STORE : ST_LREAD;
      ST_LREAD:  nxt = ST_LWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_ctrl_decode.sv
module mcs_ctrl_decode
  import mcs_pkg::*;
(
  input  state_t st,
  output ctrl_t  ctrl
);

  pc_uop_t  pc_u;
  mem_uop_t mem_u;
  rf_uop_t  rf_u;
  alu_uop_t alu_u;

  // state -> combination of group micro-operations
  always_comb begin
    pc_u  = PCU_HOLD;
    mem_u = MEMU_IDLE;
    rf_u  = RFU_IDLE;
    alu_u = ALUU_IDLE;
    case (st)
      ST_FETCH:  begin pc_u = PCU_STEP; mem_u = MEMU_FETCH; alu_u = ALUU_STEP; end
      ST_DECODE: begin rf_u = RFU_OPERANDS; alu_u = ALUU_BRTGT; end
      ST_EXEC:   alu_u = ALUU_ARITH;
      ST_RWB:    rf_u  = RFU_RES2RD;
      ST_MADDR:  alu_u = ALUU_ADDR;
      ST_STORE:  mem_u = MEMU_WRITE;
      ST_LREAD:  mem_u = MEMU_READ;
      ST_LWB:    rf_u  = RFU_DR2RT;
      ST_BRANCH: begin pc_u = PCU_COND; alu_u = ALUU_CMP; end
      ST_JUMP:   pc_u  = PCU_JUMP;
      default:   ;
    endcase
  end

  // micro-operations -> control lines; idle groups leave zeros
  always_comb begin
    ctrl = '0;
    case (pc_u)
      PCU_STEP: begin ctrl.pc_wr_always  = 1'b1; ctrl.pc_sel = 2'd1; end
      PCU_COND: begin ctrl.pc_wr_if_zero = 1'b1; ctrl.pc_sel = 2'd0; end
      PCU_JUMP: begin ctrl.pc_wr_always  = 1'b1; ctrl.pc_sel = 2'd2; end
      default:  ;
    endcase
    case (mem_u)
      MEMU_FETCH: begin ctrl.mem_rd = 1'b1; ctrl.ir_load = 1'b1; end
      MEMU_READ:  begin ctrl.mem_rd = 1'b1; ctrl.mem_addr_data = 1'b1; ctrl.dr_load = 1'b1; end
      MEMU_WRITE: begin ctrl.mem_wr = 1'b1; ctrl.mem_addr_data = 1'b1; end
      default:    ;
    endcase
    case (rf_u)
      RFU_OPERANDS: begin ctrl.a_load = 1'b1; ctrl.b_load = 1'b1; end
      RFU_RES2RD:   begin ctrl.rf_wr = 1'b1; ctrl.rf_dst_rd = 1'b1; end
      RFU_DR2RT:    begin ctrl.rf_wr = 1'b1; ctrl.rf_from_mem = 1'b1; end
      default:      ;
    endcase
    case (alu_u)
      ALUU_STEP:  begin ctrl.alu_b_sel = 2'd1; ctrl.alu_mode = MODE_ADD; end
      ALUU_BRTGT: begin ctrl.alu_b_sel = 2'd3; ctrl.alu_mode = MODE_ADD; ctrl.res_load = 1'b1; end
      ALUU_ARITH: begin ctrl.alu_a_sel = 1'b1; ctrl.alu_mode = MODE_FUNCT; ctrl.res_load = 1'b1; end
      ALUU_ADDR:  begin ctrl.alu_a_sel = 1'b1; ctrl.alu_b_sel = 2'd2; ctrl.res_load = 1'b1; end
      ALUU_CMP:   begin ctrl.alu_a_sel = 1'b1; ctrl.alu_mode = MODE_SUB; end
      default:    ;
    endcase
  end

endmodule

// File: rtl/mcs_alu_decode.sv
module mcs_alu_decode
  import mcs_pkg::*;
#(
  parameter int            FN_W   = 6,
  parameter logic [FN_W-1:0] FN_ADD = 6'h20,
  parameter logic [FN_W-1:0] FN_SUB = 6'h22,
  parameter logic [FN_W-1:0] FN_AND = 6'h24,
  parameter logic [FN_W-1:0] FN_OR  = 6'h25,
  parameter logic [FN_W-1:0] FN_SLT = 6'h2A
) (
  input  alu_mode_t           mode,
  input  logic [FN_W-1:0]     funct,
  output logic [ALU_OP_W-1:0] alu_op
);

  logic [ALU_OP_W-1:0] fn_op;

  always_comb begin
    case (funct)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_op = ALU_ADD;
    endcase
  end

  always_comb begin
    case (mode)
      MODE_SUB:   alu_op = ALU_SUB;
      MODE_FUNCT: alu_op = fn_op;
      default:    alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mcs_pkg::*;
#(
  parameter int OP_W = 6,
  parameter int FN_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     opcode,
  input  logic [FN_W-1:0]     funct,
  output logic                pc_wr_always,
  output logic                pc_wr_if_zero,
  output logic [1:0]          pc_sel,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                mem_addr_data,
  output logic                ir_load,
  output logic                dr_load,
  output logic                rf_wr,
  output logic                rf_dst_rd,
  output logic                rf_from_mem,
  output logic                a_load,
  output logic                b_load,
  output logic                alu_a_sel,
  output logic [1:0]          alu_b_sel,
  output logic [ALU_OP_W-1:0] alu_op,
  output logic                res_load
);

  state_t state_q, state_d, state_sel;
  ctrl_t  ctrl_q, ctrl_d;

  mcs_next_state #(.OP_W(OP_W)) u_next (
    .cur    (state_q),
    .opcode (opcode),
    .nxt    (state_d)
  );

  assign state_sel = rst ? ST_FETCH : state_d;

  // decode the state being entered so the control word is registered
  mcs_ctrl_decode u_dec (
    .st   (state_sel),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_sel;
    ctrl_q  <= ctrl_d;
  end

  mcs_alu_decode #(.FN_W(FN_W)) u_alu (
    .mode   (ctrl_q.alu_mode),
    .funct  (funct),
    .alu_op (alu_op)
  );

  assign pc_wr_always  = ctrl_q.pc_wr_always;
  assign pc_wr_if_zero = ctrl_q.pc_wr_if_zero;
  assign pc_sel        = ctrl_q.pc_sel;
  assign mem_rd        = ctrl_q.mem_rd;
  assign mem_wr        = ctrl_q.mem_wr;
  assign mem_addr_data = ctrl_q.mem_addr_data;
  assign ir_load       = ctrl_q.ir_load;
  assign dr_load       = ctrl_q.dr_load;
  assign rf_wr         = ctrl_q.rf_wr;
  assign rf_dst_rd     = ctrl_q.rf_dst_rd;
  assign rf_from_mem   = ctrl_q.rf_from_mem;
  assign a_load        = ctrl_q.a_load;
  assign b_load        = ctrl_q.b_load;
  assign alu_a_sel     = ctrl_q.alu_a_sel;
  assign alu_b_sel     = ctrl_q.alu_b_sel;
  assign res_load      = ctrl_q.res_load;

  AST_RST_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_load && mem_rd && pc_wr_always)); // R1
  AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (a_load && b_load)); // R2
  AST_DECODE_ONCE: assert property (@(posedge clk) disable iff (rst)
    a_load |=> !a_load); // R3
  AST_RWB_FETCH: assert property (@(posedge clk) disable iff (rst)
    (rf_wr && !rf_from_mem) |=> ir_load); // R4
  AST_ADDR_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MADDR) |=> (mem_wr || dr_load)); // R5
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R6
  AST_DR_TO_RF: assert property (@(posedge clk) disable iff (rst)
    dr_load |=> (rf_wr && rf_from_mem)); // R7
  AST_PC_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr_always && pc_wr_if_zero)); // R8
  AST_JUMP_FETCH: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_always && pc_sel == 2'd2) |=> ir_load); // R9
  AST_CMP_SUB: assert property (@(posedge clk) disable iff (rst)
    pc_wr_if_zero |-> (alu_op == ALU_SUB)); // R10

endmodule

// File: tb/mc_sequencer_tb_top.sv
`timescale 1ns/1ps
module mc_sequencer_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct  = 6'h20;
  logic       pc_wr_always, pc_wr_if_zero, mem_rd, mem_wr, mem_addr_data;
  logic       ir_load, dr_load, rf_wr, rf_dst_rd, rf_from_mem, a_load, b_load;
  logic       alu_a_sel, res_load;
  logic [1:0] pc_sel, alu_b_sel;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  int ms = 0;        // reference state number
  bit armed = 1'b0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mc_sequencer dut_i (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .pc_wr_always(pc_wr_always), .pc_wr_if_zero(pc_wr_if_zero), .pc_sel(pc_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr_data(mem_addr_data),
    .ir_load(ir_load), .dr_load(dr_load), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
    .rf_from_mem(rf_from_mem), .a_load(a_load), .b_load(b_load),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .res_load(res_load)
  );

  // reference sequence, by state number
  function automatic int ref_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'h00) return 2;
        if (op == 6'h23 || op == 6'h2B) return 4;
        if (op == 6'h04) return 8;
        if (op == 6'h02) return 9;
        return 0;
      end
      2: return 3;
      4: return (op == 6'h2B) ? 5 : 6;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic logic [2:0] ref_fn(logic [5:0] f);
    if (f == 6'h22) return 3'b110;
    if (f == 6'h24) return 3'b000;
    if (f == 6'h25) return 3'b001;
    if (f == 6'h2A) return 3'b111;
    return 3'b010;
  endfunction

  // packed: pwa pwz psel[2] mrd mwr mad irl drl rfw rfd rfm al bl asel bsel[2] op[3] res
  function automatic logic [20:0] ref_word(int s, logic [5:0] f);
    logic pwa, pwz, mrd, mwr, mad, irl, drl, rfw, rfd, rfm, al, bl, asel, res;
    logic [1:0] psel, bsel;
    logic [2:0] op;
    {pwa, pwz, mrd, mwr, mad, irl, drl, rfw, rfd, rfm, al, bl, asel, res} = '0;
    psel = 2'd0; bsel = 2'd0; op = 3'b010;
    if (s == 0) begin pwa = 1; psel = 2'd1; mrd = 1; irl = 1; bsel = 2'd1; end
    if (s == 1) begin al = 1; bl = 1; bsel = 2'd3; res = 1; end
    if (s == 2) begin asel = 1; res = 1; op = ref_fn(f); end
    if (s == 3) begin rfw = 1; rfd = 1; end
    if (s == 4) begin asel = 1; bsel = 2'd2; res = 1; end
    if (s == 5) begin mwr = 1; mad = 1; end
    if (s == 6) begin mrd = 1; mad = 1; drl = 1; end
    if (s == 7) begin rfw = 1; rfm = 1; end
    if (s == 8) begin asel = 1; op = 3'b110; pwz = 1; end
    if (s == 9) begin pwa = 1; psel = 2'd2; end
    return {pwa, pwz, psel, mrd, mwr, mad, irl, drl, rfw, rfd, rfm, al, bl, asel, bsel, op, res};
  endfunction

  function automatic string req_of(int s);
    case (s)
      0: return "R1 R11";
      1: return "R2 R11";
      2: return "R4 R10";
      3: return "R4 R11";
      4: return "R5 R11";
      5: return "R6 R11";
      6, 7: return "R7 R11";
      8: return "R8 R11";
      default: return "R9 R11";
    endcase
  endfunction

  always @(posedge clk) ms <= rst ? 0 : ref_next(ms, opcode);

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    logic [20:0] got, exp;
    if (armed && !done) begin
      got = {pc_wr_always, pc_wr_if_zero, pc_sel, mem_rd, mem_wr, mem_addr_data, ir_load,
             dr_load, rf_wr, rf_dst_rd, rf_from_mem, a_load, b_load, alu_a_sel, alu_b_sel,
             alu_op, res_load};
      exp = ref_word(ms, funct);
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s state %0d: actual %b expected %b", req_of(ms), ms, got, exp);
      end
    end
  end

  // run one instruction from fetch; checks its length against R3
  task automatic run_instr(input logic [5:0] op, input logic [5:0] f, input int len);
    int n = 0;
    opcode = op;
    funct  = f;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      n++;
      if (ir_load === 1'b1) break;
    end
    checks++;
    if (n != len) begin
      errors++;
      $display("FAIL R3 opcode %h: actual %0d cycles expected %0d", op, n, len);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    armed = 1'b1;            // reset state compared here (R1)
    rst = 1'b0;
    run_instr(6'h00, 6'h20, 4);   // R4 add
    run_instr(6'h00, 6'h22, 4);   // R10 subtract
    run_instr(6'h00, 6'h24, 4);   // R10 and
    run_instr(6'h00, 6'h25, 4);   // R10 or
    run_instr(6'h00, 6'h2A, 4);   // R10 slt
    run_instr(6'h00, 6'h3F, 4);   // R10 unlisted funct
    run_instr(6'h23, 6'h2A, 5);   // R7 load
    run_instr(6'h2B, 6'h25, 4);   // R6 store
    run_instr(6'h04, 6'h24, 3);   // R8 branch
    run_instr(6'h02, 6'h22, 3);   // R9 jump
    run_instr(6'h3F, 6'h20, 2);   // R3 unknown opcode
    run_instr(6'h08, 6'h20, 2);   // R3 unknown opcode
    // R1: reset in the load read state
    opcode = 6'h23;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (!(ir_load === 1'b1 && dr_load === 1'b0 && rf_wr === 1'b0)) begin
      errors++;
      $display("FAIL R1 mid-load reset: actual ir=%b dr=%b rf=%b expected 1 0 0",
               ir_load, dr_load, rf_wr);
    end
    rst = 1'b0;
    run_instr(6'h23, 6'h20, 5);
    run_instr(6'h04, 6'h20, 3);
    run_instr(6'h00, 6'h2A, 4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule